// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the control unit of a multicycle processor datapath, built as a microprogram. A 4-bit micro-address register selects one entry of a constant control store. Each entry holds a 16-bit datapath control word and a 2-bit sequencing code. The control word is sent out unchanged. The sequencing code selects where the next micro-address comes from: it can return to the fetch entry, step to the next entry, or jump through one of two small opcode-indexed jump tables.

Only the two steps that branch by instruction class look at the opcode. Every other step ignores it. This keeps the store at one row per step, where a flat table would need one row for every pair of step and opcode. The datapath that consumes the control word is outside this block.

Top module: `usq_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the micro-address becomes 0. In step 0 the control word has bit 15 (program-counter write), bit 12 (memory read) and bit 10 (instruction-register write) set.
- R2: Step 0 is always followed by step 1, whatever the opcode.
- R3: The sequencing code uses these encodings: 00 returns to step 0, 01 jumps through the first table, 10 jumps through the second table, and 11 goes to the current address plus one. Steps 0, 3 and 6 use code 11. Step 1 uses code 01. Step 2 uses code 10. Steps 4, 5, 7, 8 and 9 use code 00.
- R4: The first table, used at step 1, maps opcode 6'b000000 to step 6, 6'b000010 to step 9, 6'b000100 to step 8, and both 6'b100011 and 6'b101011 to step 2.
- R5: The second table, used at step 2, maps opcode 6'b100011 to step 3 and 6'b101011 to step 5.
- R6: An opcode that a table does not list maps to step 0 in that table. This holds for both tables.
- R7: With the opcode held constant, the micro-address traces are as follows: load (100011) 0,1,2,3,4,0; store (101011) 0,1,2,5,0; register op (000000) 0,1,6,7,0; branch (000100) 0,1,8,0; jump (000010) 0,1,9,0.
- R8: In the control word, bit 1 (register write) is set only in steps 4 and 7. Bit 11 (memory write) is set only in step 5. Bit 10 (instruction-register write) is set only in step 0. Bit 15 (program-counter write) is set only in steps 0 and 9. Bit 14 (conditional program-counter write) is set only in step 8.
- R9: The opcode is sampled only in steps 1 and 2. A change of opcode in any other step has no effect on the trace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to step 0 |
| opcode_i | input | 6 | Instruction opcode field |
| ctrl_o | output | 16 | Datapath control word of the current step |
| upc_o | output | 4 | Current micro-address |

## Verification
The embedded properties check the local rules on every cycle: reset leads to step 0, step 0 leads to step 1, increment and return codes land where they should, each table only ever jumps to one of its listed targets, and the three write strobes are never set together. Only the bench scenarios can show that a particular opcode picks the correct target, that whole traces match the expected step sequences, that a table miss returns to fetch, and that opcode changes outside the decode steps have no effect.

// File: rtl/usq_pkg.sv
package usq_pkg;

   typedef enum logic [1:0] {
      SEQ_FETCH = 2'b00,
      SEQ_DISP1 = 2'b01,
      SEQ_DISP2 = 2'b10,
      SEQ_INCR  = 2'b11
   } seq_e;

   localparam int SEQ_W = 2;
   localparam int OPC_W = 6;

   localparam logic [5:0] OPC_REG   = 6'b000000;
   localparam logic [5:0] OPC_JUMP  = 6'b000010;
   localparam logic [5:0] OPC_BEQ   = 6'b000100;
   localparam logic [5:0] OPC_LOAD  = 6'b100011;
   localparam logic [5:0] OPC_STORE = 6'b101011;

   // Control word, MSB first: bit 15 down to bit 0
   typedef struct packed {
      logic       pc_wr;       // 15
      logic       pc_wr_cond;  // 14
      logic       addr_sel;    // 13 data vs instruction address
      logic       mem_rd;      // 12
      logic       mem_wr;      // 11
      logic       ir_wr;       // 10
      logic       wb_from_mem; // 9
      logic [1:0] pc_sel;      // 8:7
      logic [1:0] alu_mode;    // 6:5
      logic [1:0] opb_sel;     // 4:3
      logic       opa_sel;     // 2
      logic       rf_wr;       // 1
      logic       rf_dst_sel;  // 0
   } ctrl_t;

   localparam int CTRL_BITS = $bits(ctrl_t);

   function automatic ctrl_t step_ctrl(input int unsigned idx);
      ctrl_t c;
      c = '0;
      case (idx)
         0: begin c.mem_rd = 1'b1; c.ir_wr = 1'b1; c.pc_wr = 1'b1; c.opb_sel = 2'b01; end
         1: begin c.opb_sel = 2'b11; end
         2: begin c.opa_sel = 1'b1; c.opb_sel = 2'b10; end
         3: begin c.mem_rd = 1'b1; c.addr_sel = 1'b1; end
         4: begin c.rf_wr = 1'b1; c.wb_from_mem = 1'b1; end
         5: begin c.mem_wr = 1'b1; c.addr_sel = 1'b1; end
         6: begin c.opa_sel = 1'b1; c.alu_mode = 2'b10; end
         7: begin c.rf_wr = 1'b1; c.rf_dst_sel = 1'b1; end
         8: begin c.opa_sel = 1'b1; c.alu_mode = 2'b01; c.pc_wr_cond = 1'b1; c.pc_sel = 2'b01; end
         9: begin c.pc_wr = 1'b1; c.pc_sel = 2'b10; end
         default: c = '0;
      endcase
      return c;
   endfunction

   function automatic seq_e step_seq(input int unsigned idx);
      case (idx)
         0, 3, 6: return SEQ_INCR;
         1:       return SEQ_DISP1;
         2:       return SEQ_DISP2;
         default: return SEQ_FETCH;
      endcase
   endfunction

endpackage

// File: rtl/usq_ctrl_store.sv
module usq_ctrl_store
   import usq_pkg::*;
#(
   parameter int UA_W = 4,
   parameter int CW   = 16
) (
   input  logic [UA_W-1:0] addr_i,
   output logic [CW-1:0]   ctrl_o,
   output seq_e            seq_o
);
   localparam int DEPTH = 2 ** UA_W;
   localparam int ROW_W = CW + SEQ_W;

   if (CW != CTRL_BITS) begin : g_bad_cw
      $error("control width must match the control word type");
   end
   if (UA_W < 4) begin : g_bad_ua
      $error("micro-address too narrow for ten steps");
   end

   logic [ROW_W-1:0] rom [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      assign rom[i] = {step_ctrl(i), step_seq(i)};
   end

   logic [ROW_W-1:0] row;
   assign row    = rom[addr_i];
   assign ctrl_o = row[ROW_W-1:SEQ_W];
   assign seq_o  = seq_e'(row[SEQ_W-1:0]);

endmodule

// File: rtl/usq_dispatch.sv
module usq_dispatch
   import usq_pkg::*;
#(
   parameter int UA_W  = 4,
   parameter int OP_W  = 6,
   parameter int TABLE = 1
) (
   input  logic [OP_W-1:0] opcode_i,
   output logic [UA_W-1:0] target_o
);
   if (OP_W != OPC_W) begin : g_bad_op
      $error("opcode width must be six");
   end

   if (TABLE == 1) begin : g_tab1
      always_comb begin
         case (opcode_i)
            OPC_REG:   target_o = UA_W'(6);
            OPC_JUMP:  target_o = UA_W'(9);
            OPC_BEQ:   target_o = UA_W'(8);
            OPC_LOAD,
            OPC_STORE: target_o = UA_W'(2);
            default:   target_o = '0;
         endcase
      end
   end else if (TABLE == 2) begin : g_tab2
      always_comb begin
         case (opcode_i)
            OPC_LOAD:  target_o = UA_W'(3);
            OPC_STORE: target_o = UA_W'(5);
            default:   target_o = '0;
         endcase
      end
   end else begin : g_bad_tab
      $error("TABLE must be 1 or 2");
      assign target_o = '0;
   end

endmodule

// File: rtl/usq_next_addr.sv
module usq_next_addr
   import usq_pkg::*;
#(
   parameter int UA_W = 4
) (
   input  seq_e            seq_i,
   input  logic [UA_W-1:0] upc_i,
   input  logic [UA_W-1:0] disp1_i,
   input  logic [UA_W-1:0] disp2_i,
   output logic [UA_W-1:0] next_o
);
   logic [UA_W-1:0] upc_inc;
   assign upc_inc = upc_i + UA_W'(1);

   always_comb begin
      unique case (seq_i)
         SEQ_FETCH: next_o = '0;
         SEQ_DISP1: next_o = disp1_i;
         SEQ_DISP2: next_o = disp2_i;
         SEQ_INCR:  next_o = upc_inc;
         default:   next_o = '0;
      endcase
   end

endmodule

// File: rtl/usq_sequencer.sv
module usq_sequencer
   import usq_pkg::*;
#(
   parameter int UA_W = 4,
   parameter int OP_W = 6,
   parameter int CW   = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [OP_W-1:0] opcode_i,
   output logic [CW-1:0]   ctrl_o,
   output logic [UA_W-1:0] upc_o
);
   logic [UA_W-1:0] upc_q;
   logic [UA_W-1:0] upc_d;
   logic [UA_W-1:0] tgt1;
   logic [UA_W-1:0] tgt2;
   logic [CW-1:0]   ctrl_w;
   seq_e            seq_w;
   ctrl_t           ctrl_s;

   usq_ctrl_store #(.UA_W(UA_W), .CW(CW)) u_store (
      .addr_i (upc_q),
      .ctrl_o (ctrl_w),
      .seq_o  (seq_w)
   );

   usq_dispatch #(.UA_W(UA_W), .OP_W(OP_W), .TABLE(1)) u_disp1 (
      .opcode_i (opcode_i),
      .target_o (tgt1)
   );

   usq_dispatch #(.UA_W(UA_W), .OP_W(OP_W), .TABLE(2)) u_disp2 (
      .opcode_i (opcode_i),
      .target_o (tgt2)
   );

   usq_next_addr #(.UA_W(UA_W)) u_next (
      .seq_i   (seq_w),
      .upc_i   (upc_q),
      .disp1_i (tgt1),
      .disp2_i (tgt2),
      .next_o  (upc_d)
   );

   always_ff @(posedge clk) begin
      if (rst) upc_q <= '0;
      else     upc_q <= upc_d;
   end

   assign ctrl_s = ctrl_t'(ctrl_w);
   assign ctrl_o = ctrl_s;
   assign upc_o  = upc_q;

   AST_RESET_FETCH: assert property (@(posedge clk)
      rst |=> (upc_q == '0));                                              // R1
   AST_FETCH_DECODE: assert property (@(posedge clk) disable iff (rst)
      (upc_q == '0) |=> (upc_q == UA_W'(1)));                              // R2
   AST_INCR_STEP: assert property (@(posedge clk) disable iff (rst)
      (seq_w == SEQ_INCR) |=> (upc_q == UA_W'($past(upc_q) + UA_W'(1))));  // R3
   AST_RETURN_FETCH: assert property (@(posedge clk) disable iff (rst)
      (seq_w == SEQ_FETCH) |=> (upc_q == '0));                             // R3
   AST_DISP1_SET: assert property (@(posedge clk) disable iff (rst)
      (upc_q == UA_W'(1)) |=> (upc_q == '0 || upc_q == UA_W'(2) || upc_q == UA_W'(6)
                               || upc_q == UA_W'(8) || upc_q == UA_W'(9))); // R4
   AST_DISP2_SET: assert property (@(posedge clk) disable iff (rst)
      (upc_q == UA_W'(2)) |=> (upc_q == '0 || upc_q == UA_W'(3) || upc_q == UA_W'(5))); // R5
   AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctrl_s.mem_wr, ctrl_s.rf_wr, ctrl_s.ir_wr}));              // R8

endmodule

// File: tb/usq_sequencer_tb.sv
`timescale 1ns/1ps
module usq_sequencer_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opcode_i = 6'b0;
   logic [15:0] ctrl_o;
   logic [3:0]  upc_o;

   int n_tot = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit mon_en = 1'b0;

   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   usq_sequencer u_dut (
      .clk      (clk),
      .rst      (rst),
      .opcode_i (opcode_i),
      .ctrl_o   (ctrl_o),
      .upc_o    (upc_o)
   );

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
      n_tot++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   // R8 strobes {pc_wr, pc_wr_cond, ir_wr, mem_wr, rf_wr} expected per step
   function automatic logic [4:0] exp_strobes(input logic [3:0] a);
      exp_strobes = {(a == 0 || a == 9), (a == 8), (a == 0), (a == 5), (a == 4 || a == 7)};
   endfunction

   function automatic logic [4:0] act_strobes();
      act_strobes = {ctrl_o[15], ctrl_o[14], ctrl_o[10], ctrl_o[11], ctrl_o[1]};
   endfunction

   // driver: push expected trace, hold opcode, optionally change it at step late_at
   task automatic run_op(input logic [5:0] op, input logic [23:0] trace, input int n,
                         input int late_at, input logic [5:0] late_op, input string tag);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(trace[23-4*i -: 4]);
         tag_q.push_back(tag);
      end
      opcode_i = op;
      for (int i = 0; i < n; i++) begin
         if (i == late_at) opcode_i = late_op;
         @(negedge clk);
      end
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (mon_en) begin
            if (exp_q.size() == 0) begin
               check(16'(upc_o), 16'hffff, "R7 unexpected step");
            end else begin
               logic [3:0] a;
               string t;
               a = exp_q.pop_front();
               t = tag_q.pop_front();
               check(16'(upc_o), 16'(a), t);
               check(16'(act_strobes()), 16'(exp_strobes(a)), "R8 strobes");
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(16'(upc_o), 16'h0, "R1 reset address");
      check(16'({ctrl_o[15], ctrl_o[12], ctrl_o[10]}), 16'h7, "R1 fetch word");
      @(negedge clk);
      rst = 1'b0;
      mon_en = 1'b1;
      run_op(6'b100011, 24'h012340, 5, -1, 6'b0, "R7 load");
      run_op(6'b101011, 24'h012500, 4, -1, 6'b0, "R7 store R5");
      run_op(6'b000000, 24'h016700, 4, -1, 6'b0, "R7 regop R4");
      run_op(6'b000100, 24'h018000, 3, -1, 6'b0, "R7 branch R4");
      run_op(6'b000010, 24'h019000, 3, -1, 6'b0, "R7 jump R4");
      run_op(6'b111111, 24'h010000, 2, -1, 6'b0, "R6 table1 miss");
      run_op(6'b100011, 24'h012000, 3, 2, 6'b000100, "R6 table2 miss");
      run_op(6'b100011, 24'h012340, 5, 3, 6'b101011, "R9 late change load");
      run_op(6'b000000, 24'h016700, 4, 2, 6'b100011, "R9 late change regop");
      run_op(6'b101011, 24'h012500, 4, 0, 6'b101011, "R2 store repeat");
      run_op(6'b000010, 24'h019000, 3, 3, 6'b0, "R3 jump");
      mon_en = 1'b0;
      opcode_i = 6'b100011;
      repeat (3) @(negedge clk);
      #1;
      check(16'(upc_o), 16'h3, "R3 before reset");
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      #1;
      check(16'(upc_o), 16'h0, "R1 mid-run reset");
      rst = 1'b0;
      @(negedge clk);
      #1;
      check(16'(upc_o), 16'h1, "R2 after reset");
      check(16'(exp_q.size()), 16'h0, "R7 queue drained");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_tot++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
         $finish;
      end
   end

endmodule